// File: doc/BRIEF.md
# Keyed Fractional Tick Divider

This block derives a slower clock-enable stream from one of three fast tick inputs. A divisor word carries a 12-bit whole part and a 12-bit fraction. The generator emits a one-clock pulse at the end of each output period. It also drives a square-wave level that is high for the first half of each period. When fractional shaping is on, an accumulator spreads the fraction over successive periods by stretching some of them by one source tick.

Software reaches the block through two 32-bit registers, one for control and one for the divisor. Every write must carry a fixed key byte in its top eight bits, or it is dropped. Starting and stopping use a handshake. Setting the enable bit starts the generator. Clearing it lets the current period finish before the busy flag falls. A separate kill bit halts everything at once. The tick source, the shaping mode and the divisor are frozen while the generator runs.

Top module: `pwclk_gen`

## Requirements
- R1: A write to either register changes nothing unless wr_data[31:24] equals 8'h5A.
- R2: The divisor register reads back as {8'h00, whole[11:0], fraction[11:0]}. The control word is laid out as: source code in bits 3:0, enable in bit 4, kill in bit 5, busy in bit 7 (read-only), invert in bit 8 and shaping mode in bits 10:9. All other read bits are 0, and both registers read 0 after reset.
- R3: In mode 0, each output period lasts exactly max(whole, 2) selected source ticks.
- R4: In modes 1, 2 and 3, all behaving identically, the fraction is added to a 12-bit accumulator at the end of every period. A carry out of that addition lengthens the following period by one tick. Mode 0 ignores the fraction.
- R5: Source code 1 selects src_tick[0], code 6 selects src_tick[1] and code 7 selects src_tick[2]. Any other code selects no ticks, so no periods complete.
- R6: Busy rises one clock after enable is seen set. After enable is cleared, busy stays high until the running period completes. That final period still produces its pulse, and busy falls on the same clock.
- R7: While the kill bit is set, busy is forced low from the next clock, the counters are cleared, no pulses appear and the generator cannot start.
- R8: While busy is high, a control write leaves the source and mode fields unchanged, but enable, kill and invert still update. A divisor write made while busy is high is ignored entirely.
- R9: The level is high for the first floor(P/2) ticks of each period of length P and low for the rest. Control bit 8 inverts it. A stopped generator shows the level equal to the invert bit.
- R10: clk_pulse is high for exactly one clock for each completed period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 divisor |
| wr_data | input | 32 | Write word, key byte in bits 31:24 |
| rd_sel | input | 1 | Read target: 0 control, 1 divisor |
| rd_data | output | 32 | Combinational read word |
| src_tick | input | 3 | Source tick enables, one per source |
| clk_pulse | output | 1 | One-clock pulse per completed period |
| clk_level | output | 1 | Divided square-wave level |

## Verification
The bench measures the spacing between pulses and compares it against a reference accumulator. It uses fractions that carry on alternate periods and on irregular periods, and whole parts of 0 and 1. A design that applied the carry to the wrong period would shift the long periods by one slot. A design without the minimum-of-2 clamp would produce no pulses or wide ones. The stop handshake is tested mid-period: a generator that dropped busy as soon as enable cleared would lose the final pulse. Keyless writes, writes made while busy and unmapped source codes are each checked by reading back or watching the pulses. A design that leaked any of these through would show a changed field or stray pulses.

// File: rtl/pwclk_pkg.sv
package pwclk_pkg;
    localparam int INT_W  = 12;
    localparam int FRAC_W = 12;
    localparam int NSRC   = 3;
    localparam logic [7:0] WR_KEY = 8'h5A;

    // source codes that map onto src_tick[0..NSRC-1]
    localparam logic [3:0] SRC_CODE [NSRC] = '{4'd1, 4'd6, 4'd7};

    typedef struct packed {
        logic [1:0] shape;
        logic       invert;
        logic       kill;
        logic       enable;
        logic [3:0] src;
    } ctl_t;

    typedef struct packed {
        logic [INT_W-1:0]  whole;
        logic [FRAC_W-1:0] frac;
    } div_t;

    function automatic logic [31:0] pack_ctl(ctl_t c, logic busy);
        return {21'd0, c.shape, c.invert, busy, 1'b0, c.kill, c.enable, c.src};
    endfunction
endpackage

// File: rtl/pwclk_regs.sv
module pwclk_regs
    import pwclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        busy,
    output ctl_t        ctl_q,
    output div_t        div_q
);
    logic key_ok;
    assign key_ok = (wr_data[31:24] == WR_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            div_q <= '0;
        end else if (wr_en && key_ok) begin
            if (!wr_sel) begin
                ctl_q.enable <= wr_data[4];
                ctl_q.kill   <= wr_data[5];
                ctl_q.invert <= wr_data[8];
                if (!busy) begin
                    ctl_q.src   <= wr_data[3:0];
                    ctl_q.shape <= wr_data[10:9];
                end
            end else if (!busy) begin
                div_q <= wr_data[INT_W+FRAC_W-1:0];
            end
        end
    end

    // R1
    keyless_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31:24] != WR_KEY) |=> ($stable(ctl_q) && $stable(div_q)));
    // R8
    locked_div_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(div_q));
    // R8
    locked_src_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(ctl_q.src) && $stable(ctl_q.shape)));
endmodule

// File: rtl/pwclk_srcsel.sv
module pwclk_srcsel
    import pwclk_pkg::*;
(
    input  logic [3:0]      code,
    input  logic [NSRC-1:0] src_tick,
    output logic            tick
);
    logic [NSRC-1:0] hit;
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = (code == SRC_CODE[i]) && src_tick[i];
    end
    assign tick = |hit;
endmodule

// File: rtl/pwclk_engine.sv
module pwclk_engine #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              enable,
    input  logic              kill,
    input  logic              frac_on,
    input  logic [INT_W-1:0]  whole,
    input  logic [FRAC_W-1:0] frac,
    output logic              busy,
    output logic              pulse,
    output logic              level
);
    localparam int CW = INT_W + 1;

    logic [CW-1:0]     cnt_q, eff_int, plen, cnt_inc;
    logic [FRAC_W-1:0] acc_q;
    logic              extra_q, last;
    logic [FRAC_W:0]   acc_sum;

    always_comb begin
        eff_int = (whole < INT_W'(2)) ? CW'(2) : {1'b0, whole};
        plen    = eff_int + CW'(extra_q);
        cnt_inc = cnt_q + CW'(1);
        last    = (cnt_inc == plen);
        acc_sum = {1'b0, acc_q} + {1'b0, (frac_on ? frac : FRAC_W'(0))};
    end

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            busy    <= 1'b0;
            pulse   <= 1'b0;
            level   <= 1'b0;
            cnt_q   <= '0;
            acc_q   <= '0;
            extra_q <= 1'b0;
        end else if (!busy) begin
            pulse <= 1'b0;
            if (enable) begin
                busy    <= 1'b1;
                level   <= 1'b1;
                cnt_q   <= '0;
                acc_q   <= '0;
                extra_q <= 1'b0;
            end else begin
                level <= 1'b0;
            end
        end else if (tick) begin
            if (last) begin
                pulse   <= 1'b1;
                cnt_q   <= '0;
                acc_q   <= acc_sum[FRAC_W-1:0];
                extra_q <= acc_sum[FRAC_W];
                busy    <= enable;
                level   <= enable;
            end else begin
                pulse <= 1'b0;
                cnt_q <= cnt_inc;
                level <= (cnt_inc < (plen >> 1));
            end
        end else begin
            pulse <= 1'b0;
        end
    end

    // R7
    kill_stops_chk: assert property (@(posedge clk) disable iff (rst)
        kill |=> (!busy && !pulse));
    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (pulse || $past(kill)));
    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(enable));
endmodule

// File: rtl/pwclk_gen.sv
module pwclk_gen
    import pwclk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [31:0]     wr_data,
    input  logic            rd_sel,
    output logic [31:0]     rd_data,
    input  logic [NSRC-1:0] src_tick,
    output logic            clk_pulse,
    output logic            clk_level
);
    ctl_t ctl_q;
    div_t div_q;
    logic busy, tick, lvl_raw;

    pwclk_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .busy(busy), .ctl_q(ctl_q), .div_q(div_q)
    );

    pwclk_srcsel u_src (
        .code(ctl_q.src), .src_tick(src_tick), .tick(tick)
    );

    pwclk_engine #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_eng (
        .clk(clk), .rst(rst), .tick(tick), .enable(ctl_q.enable),
        .kill(ctl_q.kill), .frac_on(ctl_q.shape != 2'd0),
        .whole(div_q.whole), .frac(div_q.frac),
        .busy(busy), .pulse(clk_pulse), .level(lvl_raw)
    );

    assign clk_level = lvl_raw ^ ctl_q.invert;
    assign rd_data   = rd_sel ? {8'd0, div_q} : pack_ctl(ctl_q, busy);

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (!busy || clk_level != ctl_q.invert || lvl_raw));
endmodule

// File: tb/pwclk_gen_tb.sv
module pwclk_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  src_tick = 3'b001;
    logic        clk_pulse, clk_level;

    int total = 0, bad = 0;
    int exp_q[$];
    bit armed = 0;
    int cyc = 0, last_pulse = 0;
    bit seen = 0, prev_pulse = 0, wide_seen = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pwclk_gen u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .src_tick(src_tick),
        .clk_pulse(clk_pulse), .clk_level(clk_level)
    );

    task automatic chk(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // tick[1] alternates; tick[0] always on; tick[2] never
    always @(negedge clk) src_tick[1] <= ~src_tick[1];

    // monitor: compares pulse spacing against queued expectations
    always @(negedge clk) begin
        cyc++;
        if (clk_pulse && prev_pulse) wide_seen = 1;
        prev_pulse = clk_pulse;
        if (!armed) seen = 0;
        else if (clk_pulse) begin
            if (seen && exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                chk((cyc - last_pulse) == e, "R3/R4/R5 period", cyc - last_pulse, e);
            end
            seen = 1;
            last_pulse = cyc;
        end
    end

    task automatic wr(bit sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(bit sel, output logic [31:0] d);
        rd_sel = sel; #1; d = rd_data;
    endtask

    function automatic logic [31:0] ctlw(int src, int mode, bit en, bit kill, bit inv);
        return {8'h5A, 13'd0, mode[1:0], inv, 1'b0, 1'b0, kill, en, src[3:0]};
    endfunction

    task automatic halt();
        wr(0, ctlw(1, 0, 0, 1, 0));
        wr(0, ctlw(1, 0, 0, 0, 0));
    endtask

    task automatic wait_pulse(int lim, output bit found);
        found = 0;
        for (int i = 0; i < lim && !found; i++) begin
            @(negedge clk);
            if (clk_pulse) found = 1;
        end
    endtask

    task automatic count_pulses(int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_pulse) c++;
        end
    endtask

    // driver: configure, push expected periods, run until consumed
    task automatic run_seq(int whole, int frac, int mode, int src, int scale, int n);
        int acc = 0, extra = 0, p, eff;
        halt();
        wr(1, {8'h5A, whole[11:0], frac[11:0]});
        wr(0, ctlw(src, mode, 0, 0, 0));
        eff = (whole < 2) ? 2 : whole;
        for (int k = 0; k <= n; k++) begin
            int sum;
            p = eff + extra;
            if (k > 0) exp_q.push_back(p * scale);
            sum = acc + ((mode != 0) ? frac : 0);
            extra = sum >> 12;
            acc = sum & 12'hFFF;
        end
        armed = 1;
        wr(0, ctlw(src, mode, 1, 0, 0));
        for (int i = 0; i < 4000 && exp_q.size() > 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, "R3/R4 sequence consumed", exp_q.size(), 0);
        exp_q.delete();
        armed = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        bit f;
        int c;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R2 reset state
        rd(0, d); chk(d == 0, "R2 ctl reset", d, 0);
        rd(1, d); chk(d == 0, "R2 div reset", d, 0);
        chk(clk_pulse == 0 && clk_level == 0, "R9 reset outputs", clk_level, 0);
        // R1 keyless writes
        wr(1, 32'h5B_123456);
        rd(1, d); chk(d == 0, "R1 keyless divisor", d, 0);
        wr(0, 32'h00_000011);
        repeat (2) @(negedge clk);
        rd(0, d); chk(d == 0, "R1 keyless control", d, 0);
        // R2 layout
        wr(1, 32'h5A_005123);
        rd(1, d); chk(d == 32'h0000_5123, "R2 divisor readback", d, 32'h5123);
        wr(0, ctlw(7, 2, 0, 1, 1));
        rd(0, d); chk(d == 32'h0000_0527, "R2 control readback", d, 32'h527);
        halt();
        // R3 integer periods and clamp
        run_seq(4, 0, 0, 1, 1, 5);
        run_seq(1, 0, 0, 1, 1, 4);
        run_seq(0, 0, 0, 1, 1, 4);
        // R4 fractional shaping
        run_seq(3, 12'h800, 1, 1, 1, 8);
        run_seq(5, 12'h555, 3, 1, 1, 10);
        run_seq(4, 12'hC00, 2, 1, 1, 8);
        run_seq(3, 12'h800, 0, 1, 1, 6);
        // R5 sources
        run_seq(3, 0, 0, 6, 2, 4);
        halt();
        wr(1, {8'h5A, 12'd3, 12'd0});
        wr(0, ctlw(7, 0, 1, 0, 0));
        count_pulses(40, c); chk(c == 0, "R5 code 7 idle tick", c, 0);
        halt();
        wr(0, ctlw(2, 0, 1, 0, 0));
        count_pulses(40, c); chk(c == 0, "R5 unmapped code", c, 0);
        rd(0, d); chk(d[7] == 1, "R6 busy while running", d[7], 1);
        // R8 locked fields
        halt();
        wr(1, {8'h5A, 12'd3, 12'd0});
        wr(0, ctlw(1, 0, 1, 0, 0));
        @(negedge clk);
        wr(1, {8'h5A, 12'd9, 12'd7});
        rd(1, d); chk(d == 32'h0000_3000, "R8 divisor locked", d, 32'h3000);
        wr(0, ctlw(6, 1, 1, 0, 0));
        rd(0, d); chk(d[3:0] == 1 && d[10:9] == 0, "R8 src/mode locked", d[10:0], 32'h91);
        // R9 level duty, then invert while running
        halt();
        wr(1, {8'h5A, 12'd5, 12'd0});
        wr(0, ctlw(1, 0, 1, 0, 0));
        wait_pulse(20, f);
        c = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (clk_level) c++; end
        chk(c == 8, "R9 level duty", c, 8);
        wr(0, ctlw(1, 0, 1, 0, 1));
        c = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (clk_level) c++; end
        chk(c == 12, "R9 inverted duty", c, 12);
        // R6 stop drains current period
        halt();
        wr(1, {8'h5A, 12'd8, 12'd0});
        wr(0, ctlw(1, 0, 1, 0, 1));
        @(negedge clk);
        rd(0, d); chk(d[7] == 1, "R6 busy after start", d[7], 1);
        wait_pulse(20, f);
        wr(0, ctlw(1, 0, 0, 0, 1));
        rd(0, d); chk(d[7] == 1, "R6 busy holds until period ends", d[7], 1);
        wait_pulse(20, f); chk(f, "R6 final pulse", f, 1);
        rd(0, d); chk(d[7] == 0, "R6 busy fell with final pulse", d[7], 0);
        count_pulses(30, c); chk(c == 0, "R6 no pulses after stop", c, 0);
        chk(clk_level == 1, "R9 stopped level equals invert", clk_level, 1);
        // R7 kill
        wr(0, ctlw(1, 0, 1, 0, 0));
        wait_pulse(20, f);
        wr(0, ctlw(1, 0, 1, 1, 0));
        @(negedge clk);
        rd(0, d); chk(d[7] == 0, "R7 kill drops busy", d[7], 0);
        count_pulses(30, c); chk(c == 0, "R7 no pulses under kill", c, 0);
        // R10 pulse width over whole run
        chk(!wide_seen, "R10 single-clock pulses", wide_seen, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule